// File: doc/BRIEF.md
# Serial Line Transceiver Power-Down Controller

This block is the digital power manager of a multi-channel serial line transceiver. Each receiver channel gives it a two-bit level code that an analog front end has already classified. From these codes it derives a filtered line-activity flag, `invalid_n`. It also decides when to run the charge pump, when to let the line drivers leave high impedance, and when to enable the receiver outputs.

Three control pins set the mode. `force_off_n` low shuts everything down and overrides the other two pins. `force_on` high holds the transceiver powered whatever the line activity. With `force_off_n` high and `force_on` low the block runs in automatic mode: it sleeps when the lines have been idle for a window, and it wakes on the first valid sample. After a wake-up, a second window returns the block to sleep if the lines do not show sustained activity. Supply readiness is modelled as a fixed power-up delay. All windows are given in time units and converted to clock cycles from the `CLK_MHZ` parameter.

Top module: `line_power_ctrl`

## Requirements
- R1: When `force_off_n` is low, `pump_en` and `tx_oe` are low, whatever the value of `force_on` and the line codes.
- R2: When `force_off_n` is high and `force_on` is high, the block powers up and stays powered, even while every line is invalid.
- R3: `invalid_n` falls after INVL_CYC consecutive clock samples in which no channel carries the valid code. Channel c occupies `line_lvl[2c+1:2c]`; 2'b01 means valid, 2'b00 means invalid, 2'b10 and 2'b11 mean indeterminate.
- R4: `invalid_n` rises after INVH_CYC consecutive samples in which at least one channel is valid. A sample with no valid channel restarts this count.
- R5: In automatic mode the block wakes (`pump_en` high) on the first sample with a valid channel. It powers down one cycle after `invalid_n` goes low, once the wake window has expired.
- R6: `tx_oe` rises exactly PUP_CYC cycles after `pump_en` rises, and it is low whenever `pump_en` is low.
- R7: `rx_oe` follows `rx_en` with two cycles of latency and does not depend on the power state.
- R8: `invalid_n` tracks line activity in forced-off, forced-on and automatic modes.
- R9: After an automatic wake-up with `invalid_n` still low, the block powers down WIN_CYC+1 cycles after the wake edge unless `invalid_n` has risen by then.
- R10: An indeterminate code neither counts as valid nor restarts the idle count of R3.
- R11: During and after reset, `pump_en`, `tx_oe`, `rx_oe` and `invalid_n` are low.
- R12: A change on `force_off_n` or `force_on` takes effect on the power state at the third rising clock edge after the change. The pins pass through two synchronizer flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_lvl | input | 2*N_CH | Per-channel level codes |
| force_off_n | input | 1 | Active-low forced shutdown (asynchronous pin) |
| force_on | input | 1 | Active-high forced power-up (asynchronous pin) |
| rx_en | input | 1 | Receiver output enable request (asynchronous pin) |
| invalid_n | output | 1 | Low when no valid level has persisted on any line |
| pump_en | output | 1 | Charge pump enable |
| tx_oe | output | 1 | Line driver output enable; drivers are high impedance when low |
| rx_oe | output | 1 | Receiver output enable |

## Verification
A wrong run counter in the activity filter shows up as `invalid_n` moving one or more cycles early or late, so the first idle or active stretch exposes it. A wrong power state shows up at once on `pump_en` or `tx_oe`. A ramp count that is off by one moves the `tx_oe` edge away from exactly PUP_CYC cycles after `pump_en`. A lost wake window shows up as a premature or missing shutdown after a short activity burst, within WIN_CYC+1 cycles of the wake.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {
    LVL_IDLE  = 2'b00,
    LVL_VALID = 2'b01,
    LVL_MID_A = 2'b10,
    LVL_MID_B = 2'b11
  } lvl_e;

  typedef enum logic [1:0] {
    PW_OFF  = 2'b00,
    PW_RAMP = 2'b01,
    PW_ON   = 2'b10
  } pwr_e;
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/spd_activity.sv
module spd_activity
  import spd_pkg::*;
#(
  parameter int N_CH     = 2,
  parameter int INVL_CYC = 7500,
  parameter int INVH_CYC = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_CH-1:0] line_lvl,
  output logic              any_valid,
  output logic              invalid_n
);
  localparam int IW = $clog2(INVL_CYC + 1);
  localparam int VW = $clog2(INVH_CYC + 1);
  localparam logic [IW-1:0] INVL_MAX = IW'(INVL_CYC);
  localparam logic [VW-1:0] INVH_MAX = VW'(INVH_CYC);

  logic [N_CH-1:0] ch_valid;

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
      assign ch_valid[c] = (lvl_e'(line_lvl[2*c +: 2]) == LVL_VALID);
    end
  endgenerate

  assign any_valid = |ch_valid;

  logic [IW-1:0] idle_q, idle_d;
  logic [VW-1:0] act_q, act_d;
  logic          flag_q, flag_d;

  // Run-length counters; indeterminate samples count as not valid (R10)
  always_comb begin
    idle_d = idle_q;
    act_d  = act_q;
    if (any_valid) begin
      idle_d = '0;
      if (act_q != INVH_MAX) act_d = act_q + 1'b1;
    end else begin
      act_d = '0;
      if (idle_q != INVL_MAX) idle_d = idle_q + 1'b1;
    end
    if (flag_q) flag_d = (idle_d != INVL_MAX);
    else        flag_d = (act_d == INVH_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      act_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      act_q  <= act_d;
      flag_q <= flag_d;
    end
  end

  assign invalid_n = flag_q;

  // R3: the flag only falls after a sample with no valid channel
  a_r3_fall_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(!any_valid));
  // R4: the flag only rises after a sample with a valid channel
  a_r4_rise_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(any_valid));
endmodule

// File: rtl/spd_power.sv
module spd_power
  import spd_pkg::*;
#(
  parameter int PUP_CYC = 25000,
  parameter int WIN_CYC = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic foff_n_s,
  input  logic fon_s,
  input  logic any_valid,
  input  logic invalid_n,
  output logic pump_en,
  output logic tx_oe
);
  localparam int PW = $clog2(PUP_CYC + 1);
  localparam int WW = $clog2(WIN_CYC + 1);
  localparam logic [PW-1:0] PUP_LAST = PW'(PUP_CYC - 1);
  localparam logic [WW-1:0] WIN_MAX  = WW'(WIN_CYC);

  pwr_e          st_q, st_d;
  logic [PW-1:0] pup_q, pup_d;
  logic [WW-1:0] win_q, win_d;
  logic          auto_mode, kill;

  assign auto_mode = foff_n_s && !fon_s;
  assign kill      = auto_mode && !invalid_n && (win_q == WIN_MAX);

  always_comb begin
    st_d  = st_q;
    pup_d = pup_q;
    win_d = win_q;
    if (st_q != PW_OFF && win_q != WIN_MAX) win_d = win_q + 1'b1;
    if (!foff_n_s) begin
      st_d = PW_OFF;
    end else begin
      unique case (st_q)
        PW_OFF: begin
          if (fon_s || any_valid) begin
            st_d  = PW_RAMP;
            pup_d = '0;
            win_d = '0;
          end
        end
        PW_RAMP: begin
          if (kill)                 st_d = PW_OFF;
          else if (pup_q == PUP_LAST) st_d = PW_ON;
          else                      pup_d = pup_q + 1'b1;
        end
        PW_ON: begin
          if (kill) st_d = PW_OFF;
        end
        default: st_d = PW_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PW_OFF;
      pup_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      pup_q <= pup_d;
      win_q <= win_d;
    end
  end

  assign pump_en = (st_q != PW_OFF);
  assign tx_oe   = (st_q == PW_ON);

  // R1: forced shutdown dominates
  a_r1_force_off: assert property (@(posedge clk) disable iff (!rst_n)
    !foff_n_s |=> (st_q == PW_OFF));
  // R2: forced power-up never drops
  a_r2_force_on_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (foff_n_s && fon_s && st_q != PW_OFF) |=> (st_q != PW_OFF));
  // R5: wake on a valid sample
  a_r5_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PW_OFF && foff_n_s && any_valid) |=> (st_q == PW_RAMP));
  // R9: sleep once the wake window expires with lines still idle
  a_r9_rearm_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != PW_OFF && auto_mode && !invalid_n && win_q == WIN_MAX) |=> (st_q == PW_OFF));
endmodule

// File: rtl/line_power_ctrl.sv
module line_power_ctrl #(
  parameter int N_CH    = 2,
  parameter int CLK_MHZ = 250,
  parameter int INVL_US = 30,
  parameter int INVH_NS = 1000,
  parameter int PUP_US  = 100,
  parameter int WIN_US  = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*N_CH-1:0] line_lvl,
  input  logic              force_off_n,
  input  logic              force_on,
  input  logic              rx_en,
  output logic              invalid_n,
  output logic              pump_en,
  output logic              tx_oe,
  output logic              rx_oe
);
  localparam int INVL_CYC = CLK_MHZ * INVL_US;
  localparam int INVH_RAW = (CLK_MHZ * INVH_NS + 999) / 1000;
  localparam int INVH_CYC = (INVH_RAW < 1) ? 1 : INVH_RAW;
  localparam int PUP_CYC  = CLK_MHZ * PUP_US;
  localparam int WIN_CYC  = CLK_MHZ * WIN_US;

  logic [2:0] pins_s;
  logic       any_valid;

  spd_sync #(.W(3)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({force_off_n, force_on, rx_en}),
    .q     (pins_s)
  );

  spd_activity #(
    .N_CH     (N_CH),
    .INVL_CYC (INVL_CYC),
    .INVH_CYC (INVH_CYC)
  ) u_act (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_lvl  (line_lvl),
    .any_valid (any_valid),
    .invalid_n (invalid_n)
  );

  spd_power #(
    .PUP_CYC (PUP_CYC),
    .WIN_CYC (WIN_CYC)
  ) u_pwr (
    .clk       (clk),
    .rst_n     (rst_n),
    .foff_n_s  (pins_s[2]),
    .fon_s     (pins_s[1]),
    .any_valid (any_valid),
    .invalid_n (invalid_n),
    .pump_en   (pump_en),
    .tx_oe     (tx_oe)
  );

  assign rx_oe = pins_s[0];
endmodule

// File: tb/tb_line_power_ctrl.sv
`timescale 1ns/1ps
module tb_line_power_ctrl;
  // Windows scaled down: the design is told the clock is 4 MHz
  localparam int N_CH = 2;
  localparam int M_INVL = 4 * 30;
  localparam int M_INVH = 4;
  localparam int M_PUP  = 4 * 100;
  localparam int M_WIN  = 4 * 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] lvl = 4'b0000;
  logic foff_n = 1'b1, fon = 1'b0, rxe = 1'b1;
  logic inv_n, pump, txo, rxo;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  line_power_ctrl #(.N_CH(N_CH), .CLK_MHZ(4)) dut (
    .clk(clk), .rst_n(rst_n), .line_lvl(lvl), .force_off_n(foff_n),
    .force_on(fon), .rx_en(rxe), .invalid_n(inv_n), .pump_en(pump),
    .tx_oe(txo), .rx_oe(rxo));

  // Behavioural reference model
  int m_pw, m_ramp, m_wake, m_nrun, m_vrun;
  bit m_flag, m_anyv;
  bit pin_q[$:2];
  bit m_off1, m_off2, m_on1, m_on2, m_rx1, m_rx2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pw = 0; m_ramp = 0; m_wake = 0; m_nrun = 0; m_vrun = 0; m_flag = 0;
      m_off1 = 0; m_off2 = 0; m_on1 = 0; m_on2 = 0; m_rx1 = 0; m_rx2 = 0;
    end else begin
      m_anyv = 0;
      for (int c = 0; c < N_CH; c++) if (lvl[2*c +: 2] == 2'b01) m_anyv = 1;
      if (!m_off2) m_pw = 0;
      else if (m_pw == 0) begin
        if (m_on2 || m_anyv) begin m_pw = 1; m_ramp = 0; m_wake = 0; end
      end else if (!m_on2 && !m_flag && m_wake >= M_WIN) m_pw = 0;
      else begin
        if (m_pw == 1) begin
          if (m_ramp == M_PUP - 1) m_pw = 2; else m_ramp++;
        end
        m_wake++;
      end
      if (m_anyv) begin m_vrun++; m_nrun = 0; end
      else begin m_nrun++; m_vrun = 0; end
      m_flag = m_flag ? !(m_nrun >= M_INVL) : (m_vrun >= M_INVH);
      m_off2 = m_off1; m_off1 = foff_n;
      m_on2  = m_on1;  m_on1  = fon;
      m_rx2  = m_rx1;  m_rx1  = rxe;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3/R4 invalid_n vs model", inv_n, m_flag);
      chk("R1/R5 pump_en vs model", pump, m_pw != 0);
      chk("R6 tx_oe vs model", txo, m_pw == 2);
      chk("R7 rx_oe vs model", rxo, m_rx2);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    wt(3);
    chk("R11 reset pump_en", pump, 1'b0);
    chk("R11 reset tx_oe", txo, 1'b0);
    chk("R11 reset invalid_n", inv_n, 1'b0);
    chk("R11 reset rx_oe", rxo, 1'b0);
    rst_n = 1'b1;
    wt(1);
    chk("R11 after reset pump_en", pump, 1'b0);
    chk("R11 after reset invalid_n", inv_n, 1'b0);
    wt(200);
    chk("R5 idle lines stay asleep", pump, 1'b0);
    lvl = 4'b0001;                       // channel 0 valid
    wt(10);
    chk("R5 wake on valid", pump, 1'b1);
    chk("R4 invalid_n high after run", inv_n, 1'b1);
    chk("R6 tx_oe waits for ramp", txo, 1'b0);
    wt(450);
    chk("R6 tx_oe after ramp", txo, 1'b1);
    lvl = 4'b1010;                       // all indeterminate
    wt(60);
    chk("R10 indeterminate mid-window", inv_n, 1'b1);
    wt(80);
    chk("R10 r3_ indeterminate counted idle", inv_n, 1'b0);
    chk("R5 sleep after flag low", pump, 1'b0);
    chk("R6 tx_oe low when asleep", txo, 1'b0);
    lvl = 4'b0100;                       // channel 1 valid briefly
    wt(3);
    lvl = 4'b0000;
    wt(5);
    chk("R4 short run keeps flag low", inv_n, 1'b0);
    chk("R9 woken by short run", pump, 1'b1);
    wt(130);
    chk("R9 back asleep after window", pump, 1'b0);
    fon = 1'b1;
    wt(500);
    chk("R2 forced on pump_en", pump, 1'b1);
    chk("R2 forced on tx_oe", txo, 1'b1);
    chk("R8 flag low while forced on", inv_n, 1'b0);
    foff_n = 1'b0;
    wt(2);
    chk("R12 not yet through synchronizer", pump, 1'b1);
    wt(1);
    chk("R1 R12 force-off beats force-on", pump, 1'b0);
    chk("R1 tx_oe off", txo, 1'b0);
    rxe = 1'b0;
    wt(1);
    chk("R7 rx_oe latency", rxo, 1'b1);
    wt(1);
    chk("R7 rx_oe follows", rxo, 1'b0);
    lvl = 4'b0001;
    wt(10);
    chk("R8 flag high while forced off", inv_n, 1'b1);
    chk("R1 stays off with valid lines", pump, 1'b0);
    rxe = 1'b1;
    fon = 1'b0;
    foff_n = 1'b1;
    wt(10);
    chk("R5 auto wake on release", pump, 1'b1);
    chk("R7 rx_oe back on", rxo, 1'b1);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule